// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog that counts down in coarse ticks and resets the system when software stops servicing it. It has eleven 16-bit registers, each in a 32-bit slot of a simple single-cycle bus. Every action that changes the timer's state needs a 16-bit key word. Reloading needs one key. Resuming needs another. Stopping needs two keys written back to back. Writes that carry the wrong value are dropped. Status reads return code words rather than single flag bits.

A prescaler divides the block clock into ticks of `TICK_DIV` cycles. With the slow 32 kHz clock, the default of 320 cycles gives a 10 ms tick. The counter is 15 bits wide. On the tick before expiry the block latches a warning event. That event drives an interrupt line through a mask, and software can also force the line through a separate bit. When the counter reaches zero, the block does four things:
- it pulses `sys_rst` for `RST_LEN` cycles;
- it records the timeout in the status word;
- it reloads the counter;
- it keeps running.

An attached debugger freezes the timer unless an override bit keeps it running.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the timer is stopped and the outputs and registers read as follows:
  - offset 0x0C reads 0xDABE;
  - status (0x10) reads 0x0000;
  - count (0x14) reads 0x0000;
  - the timeout register (0x04) reads `TMO_INIT`;
  - `irq` and `sys_rst` are low.
- R2: Writing 0xFEED to offset 0x00 loads the count from the timeout register and restarts the prescaler. Any other value written there leaves the count unchanged.
- R3: The timeout register at 0x04 keeps only bits 14:0 of a write and reads back with bit 15 at zero.
- R4: Stopping the timer takes two consecutive bus writes: 0x2BAD to offset 0x08, then 0xCAFE to offset 0x0C. A wrong key, or any other write between the two, leaves the timer running. Offset 0x0C reads 0x0000 while the timer runs and 0xDABE while it is stopped.
- R5: Writing 0xACED to offset 0x1C starts a stopped timer and restarts the prescaler; any other value there is ignored. While running, the count drops by one every `TICK_DIV` cycles.
- R6: Expiry happens on a tick while the count is 1 (or 0). At expiry:
  - `sys_rst` goes high for exactly `RST_LEN` cycles;
  - status reads 0xCFE8;
  - the count reloads from the timeout register.
  
  Writing 0xE8B4 to 0x10 returns status to 0x0000; any other value there is ignored.
- R7: Count reads at 0x14 return the remaining count in bits 14:0. Bit 15 is 1 only in the cycle whose closing edge applies a tick.
- R8: The warning event works as follows:
  - it sits in bit 0 of 0x20 and is set by the tick that takes the count from 2 to 1;
  - writing 1 to that bit clears it;
  - mask is bit 0 of 0x24 and force is bit 0 of 0x28;
  - `irq` = mask AND (event OR force), and force does not set the event.
- R9: Offset 0x18 reads `dbg_attached` in bit 1 and a writable override in bit 0. While `dbg_attached` is high and the override is 0, the count and prescaler hold. Setting the override lets counting resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timer clock, also used for the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 6 | Byte address; bits 5:2 pick the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| dbg_attached | input | 1 | High while a debugger is attached |
| irq | output | 1 | Masked pre-expiry interrupt |
| sys_rst | output | 1 | Reset pulse issued on expiry |

## Verification
The hardest situation to reach is the full expiry sequence, because the warning tick, the expiry tick, the reset pulse and the reload must each be seen on their exact cycle. The bench sets the timeout to 3 and starts the prescaler from a known phase with a reload followed by a resume. It then reads one register per cycle, so each read lands at a cycle offset that can be counted from the resume edge. The bench then checks:
- the unstable bit;
- the warning event;
- the reset pulse edges;
- the reloaded count

against that count.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          TICK_DIV = 320,
  parameter int          RST_LEN  = 32,
  parameter logic [14:0] TMO_INIT = 15'd6000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        dbg_attached,
  output logic        irq,
  output logic        sys_rst
);
  localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int RL_W  = $clog2(RST_LEN + 1);
  localparam logic [15:0] K_FEED = 16'hFEED, K_D1 = 16'h2BAD, K_D2 = 16'hCAFE;
  localparam logic [15:0] K_RES  = 16'hACED, K_CLR = 16'hE8B4;
  localparam logic [15:0] C_OFF  = 16'hDABE, C_TO = 16'hCFE8;

  logic [PRE_W-1:0] pre_q;
  logic [14:0]      cnt_q, tmo_q;
  logic [RL_W-1:0]  rcnt_q;
  logic en_q, armed_q, timed_out_q, ovr_q, mask_q, force_q, evt_q;

  wire [3:0] idx   = bus_addr[5:2];
  wire       wr_en = bus_sel & bus_wr;
  logic unused_ok;
  assign unused_ok = ^bus_addr[1:0];

  wire feed_hit = wr_en && idx == 4'd0 && bus_wdata == K_FEED;
  wire d1_hit   = wr_en && idx == 4'd2 && bus_wdata == K_D1;
  wire d2_hit   = wr_en && idx == 4'd3 && bus_wdata == K_D2 && armed_q;
  wire rs_hit   = wr_en && idx == 4'd7 && bus_wdata == K_RES;
  wire clr_hit  = wr_en && idx == 4'd4 && bus_wdata == K_CLR;

  wire run     = en_q & (~dbg_attached | ovr_q);
  wire tick    = run && pre_q == PRE_W'(TICK_DIV - 1);
  wire expire  = tick && cnt_q <= 15'd1;
  wire pre_evt = tick && cnt_q == 15'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      tmo_q <= TMO_INIT;
      en_q <= 1'b0;
      armed_q <= 1'b0;
      timed_out_q <= 1'b0;
      ovr_q <= 1'b0;
      mask_q <= 1'b0;
      force_q <= 1'b0;
      evt_q <= 1'b0;
      rcnt_q <= '0;
    end else begin
      if (feed_hit || rs_hit || tick) pre_q <= '0;
      else if (run)                   pre_q <= pre_q + 1'b1;

      if (feed_hit || expire) cnt_q <= tmo_q;
      else if (tick)          cnt_q <= cnt_q - 15'd1;

      if (d2_hit)      en_q <= 1'b0;
      else if (rs_hit) en_q <= 1'b1;

      if (wr_en) armed_q <= d1_hit;

      if (wr_en && idx == 4'd1) tmo_q <= bus_wdata[14:0];

      if (expire)       timed_out_q <= 1'b1;
      else if (clr_hit) timed_out_q <= 1'b0;

      if (wr_en && idx == 4'd6)  ovr_q   <= bus_wdata[0];
      if (wr_en && idx == 4'd9)  mask_q  <= bus_wdata[0];
      if (wr_en && idx == 4'd10) force_q <= bus_wdata[0];

      if (pre_evt) evt_q <= 1'b1;
      else if (wr_en && idx == 4'd8 && bus_wdata[0]) evt_q <= 1'b0;

      if (expire)           rcnt_q <= RL_W'(RST_LEN);
      else if (rcnt_q != 0) rcnt_q <= rcnt_q - 1'b1;
    end
  end

  always_comb begin
    case (idx)
      4'd1:    bus_rdata = {1'b0, tmo_q};
      4'd3:    bus_rdata = en_q ? 16'h0000 : C_OFF;
      4'd4:    bus_rdata = timed_out_q ? C_TO : 16'h0000;
      4'd5:    bus_rdata = {tick, cnt_q};
      4'd6:    bus_rdata = {14'd0, dbg_attached, ovr_q};
      4'd8:    bus_rdata = {15'd0, evt_q};
      4'd9:    bus_rdata = {15'd0, mask_q};
      4'd10:   bus_rdata = {15'd0, force_q};
      default: bus_rdata = 16'h0000;
    endcase
  end

  assign irq     = mask_q & (evt_q | force_q);
  assign sys_rst = rcnt_q != 0;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [3:0]  reg_idx,
  input logic [15:0] bus_wdata,
  input logic        en_q,
  input logic        timed_out_q,
  input logic        mask_q,
  input logic        ovr_q,
  input logic        dbg_attached,
  input logic [14:0] cnt_q,
  input logic        irq,
  input logic        sys_rst
);
  wire feed_wr = bus_sel && bus_wr && reg_idx == 4'd0 && bus_wdata == 16'hFEED;

  // R4
  a_r4_stop_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(bus_sel && bus_wr && reg_idx == 4'd3 && bus_wdata == 16'hCAFE));

  // R5
  a_r5_start_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(bus_sel && bus_wr && reg_idx == 4'd7 && bus_wdata == 16'hACED));

  // R6
  a_r6_pulse_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> timed_out_q);

  // R8
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mask_q);

  // R9
  a_r9_debug_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dbg_attached && !ovr_q && !feed_wr) |-> $stable(cnt_q));
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .reg_idx(bus_addr[5:2]), .bus_wdata(bus_wdata), .en_q(en_q),
  .timed_out_q(timed_out_q), .mask_q(mask_q), .ovr_q(ovr_q),
  .dbg_attached(dbg_attached), .cnt_q(cnt_q), .irq(irq), .sys_rst(sys_rst)
);

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, dbg = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq, sys_rst;

  keyed_wdt #(.TICK_DIV(4), .RST_LEN(3), .TMO_INIT(15'h0100)) u_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_attached(dbg), .irq(irq), .sys_rst(sys_rst)
  );

  always #5 clk = ~clk;

  typedef struct { int kind; logic [15:0] exp; string tag; } item_t;
  item_t exp_q[$];
  item_t cur;
  logic [15:0] act;
  int checks = 0, fails = 0;
  logic mon_req = 1'b0;
  logic done = 1'b0;

  always @(negedge clk) begin
    if (mon_req && exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      act = (cur.kind == 0) ? bus_rdata : (cur.kind == 1) ? {15'd0, irq} : {15'd0, sys_rst};
      checks++;
      if (act !== cur.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", cur.tag, act, cur.exp);
      end
    end
  end

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string t);
    bus_addr = a;
    exp_q.push_back('{0, e, t});
    mon_req = 1'b1;
    @(posedge clk); #1 mon_req = 1'b0;
  endtask

  task automatic pin(input int k, input logic [15:0] e, input string t);
    exp_q.push_back('{k, e, t});
    mon_req = 1'b1;
    @(posedge clk); #1 mon_req = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(6'h0C, 16'hDABE, "R1 stopped");
    rd(6'h10, 16'h0000, "R1 status");
    rd(6'h14, 16'h0000, "R1 count");
    rd(6'h04, 16'h0100, "R1 timeout");
    pin(1, 16'h0, "R1 irq");
    pin(2, 16'h0, "R1 sys_rst");

    wr(6'h04, 16'hFFFF);
    rd(6'h04, 16'h7FFF, "R3 width");

    wr(6'h04, 16'h0005);
    wr(6'h00, 16'hFEEE);
    rd(6'h14, 16'h0000, "R2 wrong key");
    wr(6'h00, 16'hFEED);
    rd(6'h14, 16'h0005, "R2 reload");

    // expiry run, timeout 3, one read per cycle after resume edge
    wr(6'h24, 16'h0001);
    wr(6'h04, 16'h0003);
    wr(6'h00, 16'hFEED);
    wr(6'h1C, 16'hACED);
    rd(6'h14, 16'h0003, "R5 i0");
    rd(6'h0C, 16'h0000, "R4 running");
    rd(6'h04, 16'h0003, "R3 i2");
    rd(6'h14, 16'h8003, "R7 unstable");
    rd(6'h14, 16'h0002, "R5 one tick");
    rd(6'h20, 16'h0000, "R8 no event yet");
    rd(6'h04, 16'h0003, "R3 i6");
    rd(6'h14, 16'h8002, "R7 unstable 2");
    rd(6'h20, 16'h0001, "R8 event");
    pin(1, 16'h1, "R8 irq");
    idle(1);
    rd(6'h14, 16'h8001, "R7 before expiry");
    pin(2, 16'h1, "R6 pulse start");
    rd(6'h10, 16'hCFE8, "R6 status");
    rd(6'h14, 16'h0003, "R6 reload");
    pin(2, 16'h0, "R6 pulse end");
    wr(6'h08, 16'h2BAD);
    wr(6'h0C, 16'hCAFE);
    rd(6'h14, 16'h0002, "R4 frozen count");
    rd(6'h0C, 16'hDABE, "R4 stopped");

    wr(6'h24, 16'h0000);
    pin(1, 16'h0, "R8 masked");
    wr(6'h24, 16'h0001);
    pin(1, 16'h1, "R8 unmasked");
    wr(6'h20, 16'h0001);
    rd(6'h20, 16'h0000, "R8 cleared");
    pin(1, 16'h0, "R8 irq off");
    wr(6'h28, 16'h0001);
    pin(1, 16'h1, "R8 forced");
    rd(6'h20, 16'h0000, "R8 force no event");
    wr(6'h28, 16'h0000);
    pin(1, 16'h0, "R8 unforced");
    wr(6'h10, 16'h1234);
    rd(6'h10, 16'hCFE8, "R6 wrong clear key");
    wr(6'h10, 16'hE8B4);
    rd(6'h10, 16'h0000, "R6 cleared");

    wr(6'h04, 16'h7FFF);
    wr(6'h00, 16'hFEED);
    wr(6'h1C, 16'hACED);
    wr(6'h08, 16'h2BAD);
    wr(6'h00, 16'h0000);
    wr(6'h0C, 16'hCAFE);
    rd(6'h0C, 16'h0000, "R4 intervening write");
    wr(6'h08, 16'h2BAD);
    wr(6'h0C, 16'hCAFF);
    wr(6'h0C, 16'hCAFE);
    rd(6'h0C, 16'h0000, "R4 wrong second key");
    wr(6'h08, 16'h2BAD);
    wr(6'h0C, 16'hCAFE);
    rd(6'h0C, 16'hDABE, "R4 proper stop");
    wr(6'h1C, 16'hACEE);
    rd(6'h0C, 16'hDABE, "R5 wrong resume key");

    dbg = 1'b1;
    wr(6'h04, 16'h000A);
    wr(6'h1C, 16'hACED);
    wr(6'h00, 16'hFEED);
    rd(6'h18, 16'h0002, "R9 attached");
    idle(6);
    rd(6'h14, 16'h000A, "R9 frozen");
    wr(6'h18, 16'h0001);
    rd(6'h18, 16'h0003, "R9 override");
    idle(3);
    rd(6'h14, 16'h0009, "R9 override runs");
    dbg = 1'b0;

    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule